// File: doc/BRIEF.md
# QoS Arbiter with LRU Tie-Break

This block shares one target port among six initiators. Read address requests and write address requests are arbitrated by two separate arbiters, so a read transaction and a write transaction can be granted in the same cycle, possibly to different initiators. Each initiator owns a 4-bit quality-of-service level for reads and another for writes. Software sets these levels through a narrow register write port.

When an arbiter is idle and sees requests, it grants the requester with the largest level. If several requesters share that largest level, the grant goes to the one whose last grant is furthest in the past. The grant is one-hot and registered. It stays on the winner until that initiator signals the end of its transaction. The arbiter then spends one idle cycle and decides again. Every new grant moves the winner to the most-recent end of a ranked order list.

Top module: `qos_lru_arbiter`

## Requirements
- R1: After reset both grant vectors are zero, every QoS level is 0, and each LRU order ranks index 0 as least recently used, then 1, 2, 3, 4 and 5.
- R2: When an arbiter is idle and exactly one initiator requests, that initiator's grant bit is set on the first clock edge after the request is seen.
- R3: A write with `cfg_we`=1 sets the level of initiator `cfg_idx` to `cfg_qos`. `cfg_wr_chan`=0 selects the read level and 1 selects the write level. An index of 6 or 7 is ignored. At an idle decision the requester with the largest level of that channel wins.
- R4: Among requesters that share the largest level, the one granted least recently wins. Each new grant moves the winner to the most-recent end of that channel's order.
- R5: A grant does not change while the granted initiator keeps its `*_last` bit low. Last bits from initiators that are not granted have no effect.
- R6: On the edge where the granted initiator's last bit is high, the grant vector goes to zero. The next decision is made on the following edge.
- R7: The read arbiter and the write arbiter decide independently. Each uses only its own requests, last bits, levels and order, so both can grant, and grant different initiators, in the same cycle.
- R8: A level write never alters a grant that is being held. A decision on the same edge as a level write uses the old value. The new value applies from the next decision.
- R9: With no request the grant vector stays zero and the LRU order is left unchanged.
- R10: Each grant vector has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | QoS level write strobe |
| cfg_wr_chan | input | 1 | 0 selects the read level, 1 selects the write level |
| cfg_idx | input | 3 | Initiator index of the write |
| cfg_qos | input | 4 | New QoS level |
| rd_req | input | 6 | Read address request, one bit per initiator |
| rd_last | input | 6 | Read transaction end, one bit per initiator |
| rd_gnt | output | 6 | One-hot read grant |
| wr_req | input | 6 | Write address request, one bit per initiator |
| wr_last | input | 6 | Write transaction end, one bit per initiator |
| wr_gnt | output | 6 | One-hot write grant |

## Verification
Two pairs of events can fall on the same clock edge, and the bench provokes both. In the first, a QoS level write coincides with an idle arbiter's decision. The bench strobes the write while requests are pending, then checks that the grant follows the old level and that the decision after it follows the new level. In the second, the read and write arbiters both decide on one edge with different requesters. The bench checks that each grant follows only its own channel's levels and order.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
    localparam int N_INIT = 6;
    localparam int QOS_W  = 4;
    localparam int IDX_W  = (N_INIT > 1) ? $clog2(N_INIT) : 1;
    localparam int N_CHAN = 2;
endpackage

// File: rtl/qos_cfg_regs.sv
module qos_cfg_regs #(
    parameter int N  = qos_arb_pkg::N_INIT,
    parameter int QW = qos_arb_pkg::QOS_W,
    parameter int IW = qos_arb_pkg::IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic            chan_sel,
    input  logic [IW-1:0]   idx,
    input  logic [QW-1:0]   val,
    output logic [N*QW-1:0] rd_qos,
    output logic [N*QW-1:0] wr_qos
);
    typedef struct packed {
        logic [N-1:0][QW-1:0] rd;
        logic [N-1:0][QW-1:0] wr;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && (int'(idx) < N)) begin
            if (chan_sel) st_d.wr[idx] = val;
            else          st_d.rd[idx] = val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_qos = st_q.rd;
    assign wr_qos = st_q.wr;
endmodule

// File: rtl/lru_qos_arb.sv
module lru_qos_arb #(
    parameter int N  = qos_arb_pkg::N_INIT,
    parameter int QW = qos_arb_pkg::QOS_W,
    parameter int IW = qos_arb_pkg::IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic [N-1:0]    last,
    input  logic [N*QW-1:0] qos_flat,
    output logic [N-1:0]    gnt
);
    typedef struct packed {
        logic [N-1:0]         gnt;
        logic [N-1:0][IW-1:0] order;  // order[0] is least recently used
    } arb_state_t;

    arb_state_t st_d, st_q;

    always_comb begin
        logic [QW-1:0] top_qos;
        logic          found;
        logic [IW-1:0] win;
        int            win_pos;
        logic [IW-1:0] cand;

        st_d    = st_q;
        top_qos = '0;
        found   = 1'b0;
        win     = '0;
        win_pos = 0;
        cand    = '0;

        // highest level among current requesters
        for (int i = 0; i < N; i++) begin
            if (req[i] && (qos_flat[i*QW +: QW] > top_qos))
                top_qos = qos_flat[i*QW +: QW];
        end

        // first requester at that level, walking from the LRU end
        for (int p = 0; p < N; p++) begin
            cand = st_q.order[p];
            if (!found && req[cand] && (qos_flat[int'(cand)*QW +: QW] == top_qos)) begin
                found   = 1'b1;
                win     = cand;
                win_pos = p;
            end
        end

        if (|st_q.gnt) begin
            if (|(st_q.gnt & last))
                st_d.gnt = '0;
        end else if (found) begin
            st_d.gnt = N'(1) << win;
            for (int p = 0; p < N - 1; p++) begin
                if (p >= win_pos)
                    st_d.order[p] = st_q.order[p+1];
            end
            st_d.order[N-1] = win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gnt <= '0;
            for (int p = 0; p < N; p++)
                st_q.order[p] <= IW'(p);
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt = st_q.gnt;
endmodule

// File: rtl/qos_lru_arbiter.sv
module qos_lru_arbiter
    import qos_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_wr_chan,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [QOS_W-1:0]  cfg_qos,
    input  logic [N_INIT-1:0] rd_req,
    input  logic [N_INIT-1:0] rd_last,
    output logic [N_INIT-1:0] rd_gnt,
    input  logic [N_INIT-1:0] wr_req,
    input  logic [N_INIT-1:0] wr_last,
    output logic [N_INIT-1:0] wr_gnt
);
    localparam int QBUS_W = N_INIT * QOS_W;

    logic [QBUS_W-1:0] rd_qos, wr_qos;
    logic [N_CHAN-1:0][N_INIT-1:0] req_ch, last_ch, gnt_ch;
    logic [N_CHAN-1:0][QBUS_W-1:0] qos_ch;

    qos_cfg_regs #(.N(N_INIT), .QW(QOS_W), .IW(IDX_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .chan_sel (cfg_wr_chan),
        .idx      (cfg_idx),
        .val      (cfg_qos),
        .rd_qos   (rd_qos),
        .wr_qos   (wr_qos)
    );

    assign req_ch[0]  = rd_req;
    assign req_ch[1]  = wr_req;
    assign last_ch[0] = rd_last;
    assign last_ch[1] = wr_last;
    assign qos_ch[0]  = rd_qos;
    assign qos_ch[1]  = wr_qos;

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        lru_qos_arb #(.N(N_INIT), .QW(QOS_W), .IW(IDX_W)) u_arb (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (req_ch[c]),
            .last     (last_ch[c]),
            .qos_flat (qos_ch[c]),
            .gnt      (gnt_ch[c])
        );
    end

    assign rd_gnt = gnt_ch[0];
    assign wr_gnt = gnt_ch[1];
endmodule

// File: rtl/qos_lru_arbiter_chk.sv
module qos_lru_arbiter_chk #(
    parameter int N = qos_arb_pkg::N_INIT
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] rd_req,
    input logic [N-1:0] rd_last,
    input logic [N-1:0] rd_gnt,
    input logic [N-1:0] wr_req,
    input logic [N-1:0] wr_last,
    input logic [N-1:0] wr_gnt
);
    AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_gnt)); // R10
    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_gnt)); // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gnt != '0 && (rd_gnt & rd_last) == '0) |=> $stable(rd_gnt)); // R5
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gnt != '0 && (wr_gnt & wr_last) == '0) |=> $stable(wr_gnt)); // R5
    AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_gnt & rd_last) != '0) |=> (rd_gnt == '0)); // R6
    AST_WR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_gnt & wr_last) != '0) |=> (wr_gnt == '0)); // R6
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gnt == '0 && rd_req == '0) |=> (rd_gnt == '0)); // R9
    AST_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gnt == '0 && wr_req == '0) |=> (wr_gnt == '0)); // R9
    AST_RD_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gnt == '0 && rd_req != '0) |=> ((rd_gnt & $past(rd_req)) != '0)); // R2
    AST_WR_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gnt == '0 && wr_req != '0) |=> ((wr_gnt & $past(wr_req)) != '0)); // R2
endmodule

bind qos_lru_arbiter qos_lru_arbiter_chk #(.N(qos_arb_pkg::N_INIT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (rd_req),
    .rd_last (rd_last),
    .rd_gnt  (rd_gnt),
    .wr_req  (wr_req),
    .wr_last (wr_last),
    .wr_gnt  (wr_gnt)
);

// File: tb/qos_lru_arbiter_bench.sv
`timescale 1ns/1ps
module qos_lru_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_wr_chan = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [3:0] cfg_qos = '0;
    logic [5:0] rd_req = '0, rd_last = '0, wr_req = '0, wr_last = '0;
    logic [5:0] rd_gnt, wr_gnt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    qos_lru_arbiter u_qos_lru_arbiter (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wr_chan(cfg_wr_chan), .cfg_idx(cfg_idx), .cfg_qos(cfg_qos),
        .rd_req(rd_req), .rd_last(rd_last), .rd_gnt(rd_gnt),
        .wr_req(wr_req), .wr_last(wr_last), .wr_gnt(wr_gnt)
    );

    // rd_req, rd_last, exp_rd, wr_req, wr_last, exp_wr
    localparam logic [35:0] VEC [14] = '{
        {6'b000000, 6'b000000, 6'b000000, 6'b000000, 6'b000000, 6'b000000},
        {6'b101000, 6'b000000, 6'b001000, 6'b000100, 6'b000000, 6'b000100},
        {6'b101000, 6'b000000, 6'b001000, 6'b000100, 6'b000000, 6'b000100},
        {6'b101000, 6'b100000, 6'b001000, 6'b000100, 6'b000000, 6'b000100},
        {6'b101000, 6'b001000, 6'b000000, 6'b000100, 6'b000100, 6'b000000},
        {6'b100000, 6'b000000, 6'b100000, 6'b000000, 6'b000000, 6'b000000},
        {6'b100000, 6'b100000, 6'b000000, 6'b000000, 6'b000000, 6'b000000},
        {6'b111111, 6'b000000, 6'b000001, 6'b000000, 6'b000000, 6'b000000},
        {6'b111111, 6'b000001, 6'b000000, 6'b000000, 6'b000000, 6'b000000},
        {6'b111111, 6'b000000, 6'b000010, 6'b000000, 6'b000000, 6'b000000},
        {6'b111111, 6'b000010, 6'b000000, 6'b000000, 6'b000000, 6'b000000},
        {6'b111000, 6'b000000, 6'b010000, 6'b000000, 6'b000000, 6'b000000},
        {6'b111000, 6'b010000, 6'b000000, 6'b000000, 6'b000000, 6'b000000},
        {6'b000000, 6'b000000, 6'b000000, 6'b000000, 6'b000000, 6'b000000}
    };

    task automatic check(input logic [5:0] got, input logic [5:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rd_req = '0; rd_last = '0; wr_req = '0; wr_last = '0; cfg_we = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic cfg(input logic chan, input logic [2:0] idx, input logic [3:0] val);
        cfg_we = 1'b1; cfg_wr_chan = chan; cfg_idx = idx; cfg_qos = val;
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        check(rd_gnt, 6'b000000, "R1 read grant after reset");
        check(wr_gnt, 6'b000000, "R1 write grant after reset");
        // R1: index 6 write ignored; all levels 0, ties follow reset order
        cfg(1'b0, 3'd6, 4'd15);

        for (int v = 0; v < 14; v++) begin
            rd_req  = VEC[v][35:30];
            rd_last = VEC[v][29:24];
            wr_req  = VEC[v][17:12];
            wr_last = VEC[v][11:6];
            step();
            check(rd_gnt, VEC[v][23:18], $sformatf("R2 R4 R5 R6 R9 table row %0d read", v));
            check(wr_gnt, VEC[v][5:0],   $sformatf("R7 table row %0d write", v));
        end

        // R3 R4: level priority with LRU tie
        do_reset();
        cfg(1'b0, 3'd5, 4'd9);
        cfg(1'b0, 3'd2, 4'd9);
        cfg(1'b0, 3'd1, 4'd3);
        rd_req = 6'b100110;
        step();
        check(rd_gnt, 6'b000100, "R3 highest level, tie to LRU");
        rd_last = 6'b000100;
        step();
        check(rd_gnt, 6'b000000, "R6 release");
        rd_last = '0;
        step();
        check(rd_gnt, 6'b100000, "R4 tie goes to other after use");
        rd_last = 6'b100000;
        step();
        rd_last = '0; rd_req = '0;

        // R3 R7: write-channel level separate from read level
        cfg(1'b1, 3'd4, 4'd15);
        wr_req = 6'b010001; rd_req = 6'b010001;
        step();
        check(wr_gnt, 6'b010000, "R3 write level decides write grant");
        check(rd_gnt, 6'b000001, "R7 read grant uses read levels and order");
        rd_req = '0; rd_last = 6'b000001;
        step();
        rd_last = '0;

        // R8: level writes during a held grant
        cfg(1'b1, 3'd4, 4'd0);
        check(wr_gnt, 6'b010000, "R8 held grant after level write");
        cfg(1'b1, 3'd0, 4'd15);
        check(wr_gnt, 6'b010000, "R8 held grant after second write");
        wr_last = 6'b010000;
        step();
        check(wr_gnt, 6'b000000, "R6 write release");
        wr_last = '0;
        step();
        check(wr_gnt, 6'b000001, "R8 new level used at next decision");
        wr_last = 6'b000001;
        step();
        wr_last = '0;
        cfg(1'b1, 3'd4, 4'd15);  // same edge as decision
        check(wr_gnt, 6'b000001, "R8 decision on write edge uses old level");
        wr_last = 6'b000001;
        step();
        wr_last = '0;
        step();
        check(wr_gnt, 6'b010000, "R4 equal levels, least recent wins");

        // R9: idle cycles leave order untouched
        wr_last = 6'b010000; wr_req = '0;
        step();
        wr_last = '0;
        for (int k = 0; k < 3; k++) begin
            step();
            check(wr_gnt, 6'b000000, "R9 no request no grant");
        end
        wr_req = 6'b010001;
        step();
        check(wr_gnt, 6'b000001, "R9 order unchanged by idle cycles");
        wr_req = '0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule